// File: doc/BRIEF.md
# Lock-Detect Charge Pump Current Controller

This block chooses the current level for a PLL charge pump and drives the selects for the loop-filter input pins. It takes single-cycle edge pulses from the reference path and from the divided oscillator path. It counts the system-clock ticks between the two edges, whichever edge arrives first, and compares that count with a threshold picked by a 2-bit code. Software can force low current at any time.

When automatic control is enabled, the block drops to low current only after a programmable number of consecutive measurements fall inside the threshold. A single measurement outside the threshold returns the pump to high current on the next cycle and discards the lock progress made so far. One of the first two filter pins is enabled according to a select bit. The third pin is enabled whenever the pump runs at high current.

Top module: `lock_cp_ctrl`

## Requirements
- R1: After reset `cp_low` is 0 and `hc_pin_en` is 1, and no lock progress is kept.
- R2: While `sw_low_req` is 1, `cp_low` is 1 in the same cycle, whatever the measurements or `auto_en` are.
- R3: While `auto_en` is 0, measurements have no effect on `cp_low`, and lowering `auto_en` clears the lock progress and the automatic low state on the next clock.
- R4: A measurement is the number of clock ticks from the sampled cycle of the first edge pulse to the sampled cycle of the opposite pulse, for either order. Pulses in the same cycle measure 0. A repeat of the first pulse before the opposite one arrives is ignored.
- R5: A measurement is in threshold when it is at most (`thr_code`+1)×`TICKS_10US` ticks, so code 0,1,2,3 stands for 10,20,30,40 µs. The limit is inclusive.
- R6: With `auto_en` 1, the automatic low state is set once the count of consecutive in-threshold measurements reaches `lock_dly`, a value of 0 acting as 1. It becomes visible on `cp_low` one clock after the completing measurement is taken.
- R7: An out-of-threshold measurement clears the count and ends the automatic low state one clock after it is taken, with no delay.
- R8: If the opposite pulse has not arrived after 2^`CNT_W`−1 ticks, a measurement of 2^`CNT_W`−1 is issued and a new measurement may start.
- R9: `filt_a_en` equals `filt_sel` and `filt_b_en` equals its inverse, so exactly one of the two is 1.
- R10: `hc_pin_en` is 1 exactly when `cp_low` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_pulse | input | 1 | One-cycle reference edge pulse |
| div_pulse | input | 1 | One-cycle divided-oscillator edge pulse |
| sw_low_req | input | 1 | Software request for low current |
| auto_en | input | 1 | Enables automatic lock-based switching |
| thr_code | input | 2 | Phase threshold select (10/20/30/40 µs) |
| lock_dly | input | DLY_W | Number of consecutive in-threshold measurements needed for lock |
| filt_sel | input | 1 | Filter input select |
| cp_low | output | 1 | 1 = low-current mode, 0 = high-current mode |
| filt_a_en | output | 1 | Enable for filter input pin 1 |
| filt_b_en | output | 1 | Enable for filter input pin 2 |
| hc_pin_en | output | 1 | Enable for filter input pin 3 (high current) |

## Verification
The bench builds the block with `TICKS_10US` = 5, `CNT_W` = 6 and `DLY_W` = 3. The four thresholds are then 5, 10, 15 and 20 ticks, so both sides of each limit take only a few cycles of pulse spacing. The timeout of 63 ticks also becomes short enough that the saturated measurement can be driven directly. With a 3-bit delay field, counts up to 7 can be run to completion, and the saturation of the lock counter can be reached as well.

// File: rtl/lcp_pkg.sv
package lcp_pkg;
   localparam int THR_STEPS = 4;
   typedef logic [1:0] thr_code_t;
endpackage

// File: rtl/lcp_phase_meter.sv
module lcp_phase_meter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_pulse,
   input  logic             div_pulse,
   output logic             meas_valid,
   output logic [CNT_W-1:0] meas
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             waiting;
   logic             first_ref;
   logic [CNT_W-1:0] cnt;
   logic             closing_edge;

   assign closing_edge = first_ref ? div_pulse : ref_pulse;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("lcp_phase_meter: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waiting    <= 1'b0;
         first_ref  <= 1'b0;
         cnt        <= '0;
         meas_valid <= 1'b0;
         meas       <= '0;
      end else begin
         meas_valid <= 1'b0;
         if (!waiting) begin
            if (ref_pulse && div_pulse) begin
               meas_valid <= 1'b1;
               meas       <= '0;
            end else if (ref_pulse || div_pulse) begin
               waiting   <= 1'b1;
               first_ref <= ref_pulse;
               cnt       <= CNT_ONE;
            end
         end else if (closing_edge || cnt == CNT_MAX) begin
            meas_valid <= 1'b1;
            meas       <= cnt;
            waiting    <= 1'b0;
         end else begin
            cnt <= cnt + CNT_ONE;
         end
      end
   end

   // coincident edges give a zero measurement on the next clock
   assert_coincident_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_pulse && div_pulse && !waiting) |=> (meas_valid && meas == '0));

   // a timed-out wait always reports the saturated value
   assert_timeout_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && cnt == CNT_MAX && !closing_edge) |=> (meas_valid && meas == CNT_MAX));
endmodule

// File: rtl/lcp_lock_filter.sv
module lcp_lock_filter
   import lcp_pkg::*;
#(
   parameter int CNT_W      = 12,
   parameter int DLY_W      = 4,
   parameter int TICKS_10US = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             meas_valid,
   input  logic [CNT_W-1:0] meas,
   input  logic             auto_en,
   input  thr_code_t        thr_code,
   input  logic [DLY_W-1:0] lock_dly,
   output logic             auto_low
);
   localparam logic [DLY_W-1:0] LCK_MAX = '1;
   localparam logic [DLY_W-1:0] LCK_ONE = DLY_W'(1);

   logic [CNT_W-1:0] thr_tab [THR_STEPS];
   logic [CNT_W-1:0] thr_ticks;
   logic [DLY_W-1:0] lock_cnt;
   logic [DLY_W-1:0] cnt_inc;
   logic             in_thr;

   generate
      if (TICKS_10US < 1) begin : g_bad_ticks
         $error("lcp_lock_filter: TICKS_10US must be positive");
      end
      if (THR_STEPS * TICKS_10US >= (2 ** CNT_W) - 1) begin : g_bad_range
         $error("lcp_lock_filter: largest threshold must stay below the timeout value");
      end
      if (DLY_W < 1) begin : g_bad_dly
         $error("lcp_lock_filter: DLY_W must be positive");
      end
      for (genvar g = 0; g < THR_STEPS; g++) begin : g_thr
         assign thr_tab[g] = CNT_W'((g + 1) * TICKS_10US);
      end
   endgenerate

   assign thr_ticks = thr_tab[thr_code];
   assign in_thr    = (meas <= thr_ticks);
   assign cnt_inc   = (lock_cnt == LCK_MAX) ? lock_cnt : lock_cnt + LCK_ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_cnt <= '0;
         auto_low <= 1'b0;
      end else if (!auto_en) begin
         lock_cnt <= '0;
         auto_low <= 1'b0;
      end else if (meas_valid) begin
         if (in_thr) begin
            lock_cnt <= cnt_inc;
            auto_low <= (cnt_inc >= lock_dly);
         end else begin
            lock_cnt <= '0;
            auto_low <= 1'b0;
         end
      end
   end

   // large phase error releases the low state on the very next clock
   assert_fast_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_valid && meas > thr_ticks) |=> !auto_low);

   // disabling automatic control drops the low state
   assert_auto_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en |=> !auto_low);

   // entering the low state needs a measurement in the cycle before
   assert_lock_on_meas_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(auto_low) |-> $past(meas_valid));
endmodule

// File: rtl/lcp_pin_drive.sv
module lcp_pin_drive (
   input  logic sw_low_req,
   input  logic auto_en,
   input  logic auto_low,
   input  logic filt_sel,
   output logic cp_low,
   output logic filt_a_en,
   output logic filt_b_en,
   output logic hc_pin_en
);
   assign cp_low    = sw_low_req | (auto_en & auto_low);
   assign hc_pin_en = ~cp_low;
   assign filt_a_en = filt_sel;
   assign filt_b_en = ~filt_sel;

   always_comb begin
      assert_sw_force_R2: assert (!sw_low_req || !hc_pin_en);
   end
endmodule

// File: rtl/lock_cp_ctrl.sv
module lock_cp_ctrl
   import lcp_pkg::*;
#(
   parameter int CNT_W      = 12,
   parameter int DLY_W      = 4,
   parameter int TICKS_10US = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_pulse,
   input  logic             div_pulse,
   input  logic             sw_low_req,
   input  logic             auto_en,
   input  logic [1:0]       thr_code,
   input  logic [DLY_W-1:0] lock_dly,
   input  logic             filt_sel,
   output logic             cp_low,
   output logic             filt_a_en,
   output logic             filt_b_en,
   output logic             hc_pin_en
);
   logic             meas_valid;
   logic [CNT_W-1:0] meas;
   logic             auto_low;

   lcp_phase_meter #(.CNT_W(CNT_W)) i_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_pulse  (ref_pulse),
      .div_pulse  (div_pulse),
      .meas_valid (meas_valid),
      .meas       (meas)
   );

   lcp_lock_filter #(
      .CNT_W      (CNT_W),
      .DLY_W      (DLY_W),
      .TICKS_10US (TICKS_10US)
   ) i_filter (
      .clk        (clk),
      .rst_n      (rst_n),
      .meas_valid (meas_valid),
      .meas       (meas),
      .auto_en    (auto_en),
      .thr_code   (thr_code_t'(thr_code)),
      .lock_dly   (lock_dly),
      .auto_low   (auto_low)
   );

   lcp_pin_drive i_pins (
      .sw_low_req (sw_low_req),
      .auto_en    (auto_en),
      .auto_low   (auto_low),
      .filt_sel   (filt_sel),
      .cp_low     (cp_low),
      .filt_a_en  (filt_a_en),
      .filt_b_en  (filt_b_en),
      .hc_pin_en  (hc_pin_en)
   );

   // exactly one of the two selectable filter pins is enabled
   assert_filt_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({filt_a_en, filt_b_en}));

   // without software request or automatic control the pump stays at high current
   assert_hc_default_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_low_req && !auto_en) |-> hc_pin_en);
endmodule

// File: tb/test_lock_cp_ctrl.sv
module test_lock_cp_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 6;
   localparam int DLY_W      = 3;
   localparam int TICKS      = 5;
   localparam int CNT_MAX    = (1 << CNT_W) - 1;
   localparam int LCK_MAX    = (1 << DLY_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_pulse = 1'b0, div_pulse = 1'b0;
   logic sw_low_req = 1'b0, auto_en = 1'b0, filt_sel = 1'b0;
   logic [1:0] thr_code = 2'd0;
   logic [DLY_W-1:0] lock_dly = '0;
   logic cp_low, filt_a_en, filt_b_en, hc_pin_en;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   string cur_req = "R1";

   // behavioural reference state
   bit m_wait = 0, m_first_ref = 0, m_valid = 0, m_low = 0;
   int m_cnt = 0, m_meas = 0, m_lock = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lock_cp_ctrl #(.CNT_W(CNT_W), .DLY_W(DLY_W), .TICKS_10US(TICKS)) i_lock_cp_ctrl (
      .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .div_pulse(div_pulse),
      .sw_low_req(sw_low_req), .auto_en(auto_en), .thr_code(thr_code),
      .lock_dly(lock_dly), .filt_sel(filt_sel), .cp_low(cp_low),
      .filt_a_en(filt_a_en), .filt_b_en(filt_b_en), .hc_pin_en(hc_pin_en)
   );

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // reference model: update at each rising edge, compare a quarter period later
   always @(posedge clk) begin
      bit closing;
      if (!rst_n) begin
         m_wait = 0; m_first_ref = 0; m_valid = 0; m_low = 0;
         m_cnt = 0; m_meas = 0; m_lock = 0;
      end else begin
         if (!auto_en) begin
            m_lock = 0; m_low = 0;
         end else if (m_valid) begin
            if (m_meas <= (int'(thr_code) + 1) * TICKS) begin
               if (m_lock < LCK_MAX) m_lock++;
               m_low = (m_lock >= int'(lock_dly));
            end else begin
               m_lock = 0; m_low = 0;
            end
         end
         m_valid = 0;
         if (!m_wait) begin
            if (ref_pulse && div_pulse) begin
               m_valid = 1; m_meas = 0;
            end else if (ref_pulse || div_pulse) begin
               m_wait = 1; m_first_ref = ref_pulse; m_cnt = 1;
            end
         end else begin
            closing = m_first_ref ? div_pulse : ref_pulse;
            if (closing || m_cnt == CNT_MAX) begin
               m_valid = 1; m_meas = m_cnt; m_wait = 0;
            end else m_cnt++;
         end
      end
      #(CLK_PERIOD / 4);
      if (rst_n && !done) begin
         check({cur_req, " cp_low"}, int'(cp_low), int'(sw_low_req | (auto_en & m_low)));
         check("R10 hc_pin_en", int'(hc_pin_en), int'(!(sw_low_req | (auto_en & m_low))));
         check("R9 filt_a_en", int'(filt_a_en), int'(filt_sel));
         check("R9 filt_b_en", int'(filt_b_en), int'(!filt_sel));
      end
   end

   // one pulse pair, k ticks apart; ref_first picks the leading edge
   task automatic pair(input bit ref_first, input int k);
      for (int i = 0; i <= k; i++) begin
         @(negedge clk);
         ref_pulse = (i == 0 && ref_first) || (i == k && !ref_first);
         div_pulse = (i == 0 && !ref_first) || (i == k && ref_first);
      end
      @(negedge clk);
      ref_pulse = 0; div_pulse = 0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      check("R1 cp_low after reset", int'(cp_low), 0);
      check("R1 hc_pin_en after reset", int'(hc_pin_en), 1);

      // R3: automatic off, in-threshold pairs do nothing
      cur_req = "R3";
      lock_dly = 3'd1;
      pair(1, 2); pair(0, 1);
      check("R3 cp_low with auto off", int'(cp_low), 0);

      // R2: software forcing
      cur_req = "R2";
      sw_low_req = 1; @(negedge clk);
      check("R2 cp_low forced", int'(cp_low), 1);
      check("R2 hc_pin_en off", int'(hc_pin_en), 0);
      sw_low_req = 0; @(negedge clk);

      // R9: filter select both ways
      filt_sel = 1; @(negedge clk);
      check("R9 pin1 selected", int'(filt_a_en), 1);
      check("R9 pin2 idle", int'(filt_b_en), 0);
      filt_sel = 0;

      // R6/R5: delay 3, threshold code 1 -> 10 ticks, limit inclusive
      cur_req = "R6";
      auto_en = 1; thr_code = 2'd1; lock_dly = 3'd3;
      pair(1, 10); pair(0, 4);
      check("R6 not yet locked after 2", int'(cp_low), 0);
      pair(1, 0);
      check("R6 locked after 3", int'(cp_low), 1);

      // R7: one large error returns high current immediately
      cur_req = "R7";
      pair(0, 11);
      check("R7 release on 11>10", int'(cp_low), 0);
      pair(1, 3);
      check("R7 count cleared", int'(cp_low), 0);

      // R5: each code at and just above its limit, delay 0 acts as 1
      cur_req = "R5";
      lock_dly = 3'd0;
      for (int c = 0; c < 4; c++) begin
         thr_code = 2'(c);
         pair(c[0], (c + 1) * TICKS);
         check("R5 at limit", int'(cp_low), 1);
         pair(!c[0], (c + 1) * TICKS + 1);
         check("R5 above limit", int'(cp_low), 0);
      end

      // R4: repeated leading pulse is ignored
      cur_req = "R4";
      thr_code = 2'd0;
      @(negedge clk); ref_pulse = 1;
      @(negedge clk); ref_pulse = 0;
      @(negedge clk); ref_pulse = 1;
      @(negedge clk); ref_pulse = 0;
      @(negedge clk); @(negedge clk); div_pulse = 1;
      @(negedge clk); div_pulse = 0;
      repeat (2) @(negedge clk);
      check("R4 span of 5 in threshold", int'(cp_low), 1);

      // R8: lone edge times out to an out-of-threshold measurement
      cur_req = "R8";
      thr_code = 2'd3;
      @(negedge clk); div_pulse = 1;
      @(negedge clk); div_pulse = 0;
      repeat (CNT_MAX + 3) @(negedge clk);
      check("R8 timeout releases", int'(cp_low), 0);

      // R6: lock counter saturation, delay 7 after 9 pairs
      cur_req = "R6";
      lock_dly = 3'd7;
      for (int i = 0; i < 9; i++) pair(i[0], 2);
      check("R6 locked at full delay", int'(cp_low), 1);

      // R3: dropping auto_en releases and clears progress
      cur_req = "R3";
      auto_en = 0; @(negedge clk);
      check("R3 release on disable", int'(cp_low), 0);
      auto_en = 1; lock_dly = 3'd2;
      pair(1, 1);
      check("R3 progress cleared", int'(cp_low), 0);

      repeat (4) @(negedge clk);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule